// File: doc/BRIEF.md
# Analog Self-Test Run Sequencer

This block steps through one self-test run of an analog signal path that is driven by a digital pattern generator and observed by a digital response accumulator. Software first sets up the run: a waveform code, an accumulator mode, the loopback path to use, and two waveform-cycle counts. It then pulses a start input. The sequencer captures the settings and takes the DAC input away from system data. It activates the chosen loopback path, clears the accumulator and loads the generator.

The run has two phases. In the first, the generator runs for a programmed number of waveform periods while accumulation is held off. This lets transients die out before anything is summed. In the second, accumulation is enabled for a programmed number of periods. Periods are counted from a one-clock pulse that the generator raises at the end of each waveform cycle, not from clock edges. When the second phase ends, the sequencer stops the generator, drops accumulation so the signature is held, and releases both multiplexers to system data. It then raises a completion flag that stays high until the next start.

A first-phase count of zero means the transient response is included in the signature. A nonzero count restricts the measurement to the steady state.

Top module: `bist_seq_top`

## Requirements
- R1: A start pulse seen in the idle or completed state produces one cycle, on the next clock, in which `genLoad` and `oraClear` are both 1 and `complete` is 0. The waveform code, accumulator mode and loopback index present with the start pulse appear on `genWave`, `oraModeOut` and `loopSelOut`.
- R2: During the warm-up phase, `genEnable` is 1 and `oraCompact` is 0. The phase lasts until `initCount` generator cycle pulses have been seen.
- R3: During the measure phase, `oraCompact` and `genEnable` are both 1 for exactly `testCount` generator cycle pulses. After the last pulse, both go to 0 on the next clock.
- R4: When `initCount` is 0, the measure phase follows the setup cycle directly, with no warm-up cycle.
- R5: `complete` rises when the measure phase ends and stays 1 until the next accepted start pulse.
- R6: Outside setup, warm-up and measure, `dacMuxSel`, `loopActive`, `genEnable`, `genLoad`, `oraClear` and `oraCompact` are 0, and `loopSelOut` is 0. Inside those phases, `dacMuxSel` and `loopActive` are 1.
- R7: While a run is in progress, a start pulse has no effect, and changes on the setting inputs do not reach `genWave`, `oraModeOut` or `loopSelOut`.
- R8: Phases advance only on `cycleDone` pulses. Any number of clocks without a pulse leaves the phase unchanged, and pulses outside warm-up and measure are ignored.
- R9: When `testCount` is 0, the run goes to the completed state right after setup or warm-up, without asserting `oraCompact`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startReq | input | 1 | One-cycle request to begin a run |
| waveSel | input | WAVE_W | Waveform code for the generator |
| oraMode | input | MODE_W | Accumulator summing mode |
| loopSel | input | LOOP_W | Index of the loopback path to activate |
| initCount | input | CNT_W | Waveform cycles with accumulation inhibited |
| testCount | input | CNT_W | Waveform cycles with accumulation enabled |
| cycleDone | input | 1 | Generator pulse at the end of each waveform cycle |
| genEnable | output | 1 | Generator running |
| genLoad | output | 1 | Generator load strobe (setup cycle) |
| genWave | output | WAVE_W | Captured waveform code |
| dacMuxSel | output | 1 | 1 selects generator data into the DAC |
| loopActive | output | 1 | Loopback multiplexer engaged |
| loopSelOut | output | LOOP_W | Captured loopback index, 0 when idle |
| oraClear | output | 1 | Accumulator clear (setup cycle) |
| oraCompact | output | 1 | Accumulator summing enabled |
| oraModeOut | output | MODE_W | Captured accumulator mode |
| complete | output | 1 | Run finished, signature held |

## Verification
The bench builds the block with `CNT_W` set to 4. This brings the largest programmable counts, 15 warm-up and 15 measure cycles, within reach in a short run, so the terminal-count compare is exercised at its extreme as well as at zero. Narrow waveform, mode and loopback fields keep every captured-setting path visible. A behavioural model of the phase sequence is compared against the outputs on every clock, and directed scenarios target starts during a run, long gaps between generator pulses, back-to-back pulses and zero counts.

// File: rtl/bist_seq_pkg.sv
package bist_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_INIT,
    ST_RUN,
    ST_DONE
  } seqState_t;

  // control -> datapath
  typedef struct packed {
    logic capture;
    logic cntClear;
    logic cntInc;
  } seqStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic initZero;
    logic testZero;
    logic initLast;
    logic testLast;
  } seqFlags_t;

endpackage

// File: rtl/bist_seq_dp.sv
module bist_seq_dp
  import bist_seq_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int WAVE_W = 4,
  parameter int MODE_W = 2,
  parameter int LOOP_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [WAVE_W-1:0] waveSel,
  input  logic [MODE_W-1:0] oraMode,
  input  logic [LOOP_W-1:0] loopSel,
  input  logic [CNT_W-1:0]  initCount,
  input  logic [CNT_W-1:0]  testCount,
  output seqFlags_t         flags,
  output logic [WAVE_W-1:0] waveQ,
  output logic [MODE_W-1:0] modeQ,
  output logic [LOOP_W-1:0] loopQ
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] initQ;
  logic [CNT_W-1:0] testQ;
  logic [CNT_W-1:0] cycCnt;

  // settings captured once per run (R1, R7)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      initQ <= '0;
      testQ <= '0;
      waveQ <= '0;
      modeQ <= '0;
      loopQ <= '0;
    end else if (strobe.capture) begin
      initQ <= initCount;
      testQ <= testCount;
      waveQ <= waveSel;
      modeQ <= oraMode;
      loopQ <= loopSel;
    end
  end

  // waveform-cycle counter, advanced only by generator pulses (R8)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cycCnt <= '0;
    end else if (strobe.cntClear) begin
      cycCnt <= '0;
    end else if (strobe.cntInc) begin
      cycCnt <= cycCnt + CNT_ONE;
    end
  end

  always_comb begin
    flags.initZero = (initQ == '0);
    flags.testZero = (testQ == '0);
    flags.initLast = (cycCnt == initQ - CNT_ONE);
    flags.testLast = (cycCnt == testQ - CNT_ONE);
  end

endmodule

// File: rtl/bist_seq_ctrl.sv
module bist_seq_ctrl
  import bist_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       cycleDone,
  input  seqFlags_t  flags,
  output seqStrobe_t strobe,
  output logic       genEnable,
  output logic       genLoad,
  output logic       oraClear,
  output logic       oraCompact,
  output logic       pathActive,
  output logic       complete
);

  seqState_t stateQ;
  seqState_t stateD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD          = stateQ;
    strobe.capture  = 1'b0;
    strobe.cntClear = 1'b0;
    strobe.cntInc   = 1'b0;
    unique case (stateQ)
      ST_IDLE, ST_DONE: begin
        if (startReq) begin
          stateD          = ST_SETUP;
          strobe.capture  = 1'b1;
          strobe.cntClear = 1'b1;
        end
      end
      ST_SETUP: begin
        if (!flags.initZero)      stateD = ST_INIT;
        else if (!flags.testZero) stateD = ST_RUN;
        else                      stateD = ST_DONE;
      end
      ST_INIT: begin
        if (cycleDone) begin
          strobe.cntInc = 1'b1;
          if (flags.initLast) begin
            strobe.cntClear = 1'b1;
            stateD = flags.testZero ? ST_DONE : ST_RUN;
          end
        end
      end
      ST_RUN: begin
        if (cycleDone) begin
          strobe.cntInc = 1'b1;
          if (flags.testLast) begin
            strobe.cntClear = 1'b1;
            stateD = ST_DONE;
          end
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_comb begin
    genLoad    = (stateQ == ST_SETUP);
    oraClear   = (stateQ == ST_SETUP);
    genEnable  = (stateQ == ST_INIT) || (stateQ == ST_RUN);
    oraCompact = (stateQ == ST_RUN);
    pathActive = (stateQ == ST_SETUP) || (stateQ == ST_INIT) || (stateQ == ST_RUN);
    complete   = (stateQ == ST_DONE);
  end

endmodule

// File: rtl/bist_seq_top.sv
module bist_seq_top
  import bist_seq_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int WAVE_W = 4,
  parameter int MODE_W = 2,
  parameter int LOOP_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic [WAVE_W-1:0] waveSel,
  input  logic [MODE_W-1:0] oraMode,
  input  logic [LOOP_W-1:0] loopSel,
  input  logic [CNT_W-1:0]  initCount,
  input  logic [CNT_W-1:0]  testCount,
  input  logic              cycleDone,
  output logic              genEnable,
  output logic              genLoad,
  output logic [WAVE_W-1:0] genWave,
  output logic              dacMuxSel,
  output logic              loopActive,
  output logic [LOOP_W-1:0] loopSelOut,
  output logic              oraClear,
  output logic              oraCompact,
  output logic [MODE_W-1:0] oraModeOut,
  output logic              complete
);

  seqStrobe_t        strobe;
  seqFlags_t         flags;
  logic              pathActive;
  logic [LOOP_W-1:0] loopQ;

  bist_seq_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startReq   (startReq),
    .cycleDone  (cycleDone),
    .flags      (flags),
    .strobe     (strobe),
    .genEnable  (genEnable),
    .genLoad    (genLoad),
    .oraClear   (oraClear),
    .oraCompact (oraCompact),
    .pathActive (pathActive),
    .complete   (complete)
  );

  bist_seq_dp #(
    .CNT_W  (CNT_W),
    .WAVE_W (WAVE_W),
    .MODE_W (MODE_W),
    .LOOP_W (LOOP_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .waveSel   (waveSel),
    .oraMode   (oraMode),
    .loopSel   (loopSel),
    .initCount (initCount),
    .testCount (testCount),
    .flags     (flags),
    .waveQ     (genWave),
    .modeQ     (oraModeOut),
    .loopQ     (loopQ)
  );

  // muxes fall back to system data outside a run (R6)
  assign dacMuxSel  = pathActive;
  assign loopActive = pathActive;
  assign loopSelOut = pathActive ? loopQ : '0;

endmodule

// File: rtl/bist_seq_chk.sv
module bist_seq_chk #(
  parameter int WAVE_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              startReq,
  input logic              cycleDone,
  input logic              genEnable,
  input logic              genLoad,
  input logic              oraClear,
  input logic              oraCompact,
  input logic              dacMuxSel,
  input logic              loopActive,
  input logic              complete,
  input logic [WAVE_W-1:0] genWave
);

  // R1: setup lasts one cycle and is followed by a phase or completion
  a_r1_setup_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    oraClear |=> (!oraClear && (genEnable || complete)));

  // R2/R3: accumulation only while the generator runs
  a_r3_compact_needs_gen: assert property (@(posedge clk) disable iff (!rstN)
    oraCompact |-> genEnable);

  // R3: accumulation stops only into the completed state
  a_r3_stop_to_done: assert property (@(posedge clk) disable iff (!rstN)
    $fell(oraCompact) |-> complete);

  // R5: completion held until a start
  a_r5_complete_hold: assert property (@(posedge clk) disable iff (!rstN)
    (complete && !startReq) |=> complete);

  // R6: idle outputs quiet
  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (!genEnable && !oraClear) |-> (!dacMuxSel && !loopActive && !oraCompact && !genLoad));

  // R7: captured waveform stable while a run is under way
  a_r7_wave_stable: assert property (@(posedge clk) disable iff (!rstN)
    genEnable |=> $stable(genWave));

  // R8: no phase change without a generator pulse
  a_r8_pulse_only: assert property (@(posedge clk) disable iff (!rstN)
    (genEnable && !cycleDone) |=> (genEnable && $stable(oraCompact)));

endmodule

bind bist_seq_top bist_seq_chk #(.WAVE_W(WAVE_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .startReq   (startReq),
  .cycleDone  (cycleDone),
  .genEnable  (genEnable),
  .genLoad    (genLoad),
  .oraClear   (oraClear),
  .oraCompact (oraCompact),
  .dacMuxSel  (dacMuxSel),
  .loopActive (loopActive),
  .complete   (complete),
  .genWave    (genWave)
);

// File: tb/bist_seq_top_tb.sv
`timescale 1ns/1ps
module bist_seq_top_tb;

  localparam int CNT_W  = 4;
  localparam int WAVE_W = 4;
  localparam int MODE_W = 2;
  localparam int LOOP_W = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0;
  logic [WAVE_W-1:0] waveSel = '0;
  logic [MODE_W-1:0] oraMode = '0;
  logic [LOOP_W-1:0] loopSel = '0;
  logic [CNT_W-1:0]  initCount = '0;
  logic [CNT_W-1:0]  testCount = '0;
  logic cycleDone = 1'b0;
  logic genEnable, genLoad, dacMuxSel, loopActive, oraClear, oraCompact, complete;
  logic [WAVE_W-1:0] genWave;
  logic [LOOP_W-1:0] loopSelOut;
  logic [MODE_W-1:0] oraModeOut;

  always #4 clk = ~clk;

  bist_seq_top #(.CNT_W(CNT_W), .WAVE_W(WAVE_W), .MODE_W(MODE_W), .LOOP_W(LOOP_W)) u_dut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .waveSel(waveSel), .oraMode(oraMode),
    .loopSel(loopSel), .initCount(initCount), .testCount(testCount), .cycleDone(cycleDone),
    .genEnable(genEnable), .genLoad(genLoad), .genWave(genWave), .dacMuxSel(dacMuxSel),
    .loopActive(loopActive), .loopSelOut(loopSelOut), .oraClear(oraClear),
    .oraCompact(oraCompact), .oraModeOut(oraModeOut), .complete(complete)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: phase 0 idle, 1 setup, 2 warm-up, 3 measure, 4 done
  int mPhase = 0;
  int mCnt = 0;
  int mInit = 0, mTest = 0, mWave = 0, mMode = 0, mLoop = 0;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPhase = 0; mCnt = 0; mInit = 0; mTest = 0; mWave = 0; mMode = 0; mLoop = 0;
    end else begin
      case (mPhase)
        0, 4: if (startReq) begin
          mPhase = 1; mCnt = 0;
          mInit = initCount; mTest = testCount;
          mWave = waveSel; mMode = oraMode; mLoop = loopSel;
        end
        1: mPhase = (mInit > 0) ? 2 : ((mTest > 0) ? 3 : 4);
        2: if (cycleDone) begin
          mCnt++;
          if (mCnt == mInit) begin mCnt = 0; mPhase = (mTest > 0) ? 3 : 4; end
        end
        3: if (cycleDone) begin
          mCnt++;
          if (mCnt == mTest) begin mCnt = 0; mPhase = 4; end
        end
        default: mPhase = 0;
      endcase
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rstN && !finished) begin
      bit act;
      act = (mPhase >= 1) && (mPhase <= 3);
      chk("R1 genLoad", int'(genLoad), int'(mPhase == 1));
      chk("R1 oraClear", int'(oraClear), int'(mPhase == 1));
      chk("R2 genEnable", int'(genEnable), int'(mPhase == 2 || mPhase == 3));
      chk("R3 oraCompact", int'(oraCompact), int'(mPhase == 3));
      chk("R5 complete", int'(complete), int'(mPhase == 4));
      chk("R6 dacMuxSel", int'(dacMuxSel), int'(act));
      chk("R6 loopActive", int'(loopActive), int'(act));
      chk("R6 loopSelOut", int'(loopSelOut), act ? mLoop : 0);
      chk("R7 genWave", int'(genWave), mWave);
      chk("R7 oraModeOut", int'(oraModeOut), mMode);
    end
  end

  task automatic cfg(input int w, input int m, input int l, input int ic, input int tc);
    waveSel = WAVE_W'(w); oraMode = MODE_W'(m); loopSel = LOOP_W'(l);
    initCount = CNT_W'(ic); testCount = CNT_W'(tc);
  endtask

  // returns at the negedge where setup is visible
  task automatic kick();
    @(negedge clk); startReq = 1'b1;
    @(negedge clk); startReq = 1'b0;
  endtask

  task automatic pulses(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); cycleDone = 1'b1;
      @(negedge clk); cycleDone = 1'b0;
      for (int g = 0; g < gap; g++) @(negedge clk);
    end
  endtask

  initial begin
    int seen;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R6 reset genEnable", int'(genEnable), 0);
    chk("R5 reset complete", int'(complete), 0);
    chk("R6 reset dacMuxSel", int'(dacMuxSel), 0);

    // R8: pulses while idle have no effect
    pulses(3, 0);
    chk("R8 idle pulses ignored", int'(genEnable | complete | oraClear), 0);

    // run A: warm-up 3, measure 4
    cfg(5, 2, 1, 3, 4);
    kick();
    chk("R1 setup clear", int'(oraClear), 1);
    chk("R1 wave captured", int'(genWave), 5);
    chk("R1 loop captured", int'(loopSelOut), 1);
    seen = 0;
    for (int i = 0; i < 7; i++) begin
      @(negedge clk); cycleDone = 1'b1;
      if (oraCompact) seen++;
      @(negedge clk); cycleDone = 1'b0;
      @(negedge clk);
    end
    chk("R3 measure pulses", seen, 4);
    chk("R5 complete after run", int'(complete), 1);
    repeat (5) @(negedge clk);
    chk("R5 complete held", int'(complete), 1);

    // run B: long gap without pulses, start during run
    cfg(3, 1, 2, 2, 2);
    kick();
    repeat (20) @(negedge clk);
    chk("R8 no pulse stays warm-up", int'(genEnable), 1);
    chk("R8 no pulse no compact", int'(oraCompact), 0);
    pulses(2, 1);
    chk("R2 warm-up done", int'(oraCompact), 1);
    cfg(9, 3, 3, 1, 1);
    startReq = 1'b1;
    @(negedge clk); startReq = 1'b0;
    @(negedge clk);
    chk("R7 start ignored", int'(oraCompact), 1);
    chk("R7 wave kept", int'(genWave), 3);
    chk("R7 loop kept", int'(loopSelOut), 2);
    pulses(2, 0);
    chk("R3 end of measure", int'(complete), 1);

    // R4: zero warm-up, maximum measure with back-to-back pulses
    cfg(7, 0, 3, 0, 15);
    kick();
    @(negedge clk);
    chk("R4 measure right after setup", int'(oraCompact), 1);
    cycleDone = 1'b1;
    repeat (14) @(negedge clk);
    chk("R3 still measuring at 14", int'(oraCompact), 1);
    @(negedge clk);
    cycleDone = 1'b0;
    chk("R3 stop at 15", int'(complete), 1);

    // R9: zero measure count
    cfg(1, 1, 1, 0, 0);
    kick();
    @(negedge clk);
    chk("R9 zero counts complete", int'(complete), 1);
    cfg(2, 2, 2, 15, 0);
    kick();
    pulses(15, 0);
    chk("R9 warm-up then complete", int'(complete), 1);
    chk("R9 no compaction", int'(oraCompact), 0);

    repeat (4) @(negedge clk);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 100000 && !finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", wd, 100000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule